// File: doc/BRIEF.md
# Endpoint DMA Request Sequencer

This block governs the data-request line that one bulk endpoint buffer presents to a DMA controller, together with the word buffer that sits behind a 16-bit data port. When the serial engine reports that a host packet has finished, the block raises its request. What lowers the request depends on the mode. In per-packet mode the CPU clears the request after it has moved each packet. In automatic-size mode the block counts the DMA accesses itself. It lowers the request once one packet's worth of 16-bit units has moved. It raises the CPU interrupt only when a down-counter, loaded with the total number of units, reaches zero.

The buffer is a word FIFO. For an OUT endpoint the serial engine fills it and DMA or the CPU empties it. For an IN endpoint DMA or the CPU fills it and the serial engine empties it. Odd byte counts are handled by the CPU through the low byte of the port. A CPU byte write stores the byte in the low half of a word. A CPU byte read removes one word, and the CPU keeps only its low byte. The received byte count of each OUT packet is latched for software to read. The control endpoint (endpoint number 0) never gets a DMA request.

Top module: `epDmaReqSeq`

## Requirements
- R1: After reset, dmaReq, irq and dmaErr are 0 and rxSizeOut is 0.
- R2: A pktDone pulse raises dmaReq in the next cycle, except in automatic-size mode with the unit counter at zero. With dirIn=0 the same pulse latches rxSize onto rxSizeOut.
- R3: In per-packet mode (autoMode=0), dmaReq stays 1 through any number of DMA accesses until a cpuClr pulse. Every pktDone sets irq.
- R4: In automatic-size mode, dmaReq falls in the cycle after the accepted access that completes ceil(pktSize/2) units of the current packet.
- R5: In automatic-size mode, each accepted access decrements the unit counter loaded by loadTotal. The access that brings it to zero lowers dmaReq and sets irq. irq stays 0 before that access.
- R6: In automatic-size mode with the unit counter at zero, pktDone leaves dmaReq at 0 until the next loadTotal.
- R7: A DMA access is an access in the active direction: dmaRd when dirIn=0, dmaWr when dirIn=1. An access with dmaEn=1 and dmaReq=0 leaves the buffer unchanged and sets dmaErr. cpuIntClr clears dmaErr and irq.
- R8: With dmaEn=0, DMA strobes are ignored: the buffer is unchanged and dmaErr stays 0.
- R9: The buffer is first-in first-out. portRdata shows the oldest word. For dirIn=0, sieWr pushes and an accepted dmaRd pops. For dirIn=1, an accepted dmaWr pushes and sieRd pops.
- R10: cpuByteWr (dirIn=1) pushes a word with cpuByte in bits 7:0 and zeros in bits 15:8. cpuByteRd (dirIn=0) pops one word whose low byte the CPU has taken from portRdata[7:0]. Neither depends on dmaReq.
- R11: When EP_NUM is 0, dmaReq stays 0 and DMA strobes do not touch the buffer.
- R12: A DMA strobe for the inactive direction (dmaWr when dirIn=0) has no effect on the buffer and does not set dmaErr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| autoMode | input | 1 | 1 selects automatic-size mode, 0 selects per-packet mode |
| dmaEn | input | 1 | DMA enable |
| dirIn | input | 1 | 1 for an IN endpoint (device to host), 0 for OUT |
| pktSize | input | PKT_W | Configured packet size in bytes |
| totalUnits | input | TOT_W | Total transfer length in 16-bit units |
| loadTotal | input | 1 | Loads totalUnits into the unit counter |
| pktDone | input | 1 | Serial engine: a host packet has finished |
| rxSize | input | PKT_W | Byte count of the finished OUT packet |
| sieWr | input | 1 | Serial engine pushes a word (OUT) |
| sieWdata | input | DATA_W | Word from the serial engine |
| sieRd | input | 1 | Serial engine pops a word (IN) |
| dmaRd | input | 1 | DMA read strobe |
| dmaWr | input | 1 | DMA write strobe |
| dmaWdata | input | DATA_W | DMA write word |
| cpuByteWr | input | 1 | CPU writes the low byte of the port |
| cpuByte | input | 8 | CPU byte |
| cpuByteRd | input | 1 | CPU reads the low byte of the port (pops) |
| cpuClr | input | 1 | CPU clears the request flag |
| cpuIntClr | input | 1 | CPU clears the interrupt and error flags |
| dmaReq | output | 1 | Request to the DMA controller |
| irq | output | 1 | CPU interrupt |
| dmaErr | output | 1 | Sticky flag for a DMA access while no request was pending |
| rxSizeOut | output | PKT_W | Latched byte count of the last OUT packet |
| portRdata | output | DATA_W | Oldest word in the buffer |

## Verification
Every flag is a single register. dmaReq, irq and dmaErr therefore change exactly one clock edge after the pulse that causes them, and rxSizeOut does the same after pktDone. portRdata is read straight from the buffer, so it shows the next word in the same cycle that a pop lands. The bench drives each pulse for one cycle just after a rising edge. It compares outputs one time unit after the following edge, when the pulse has taken effect and before the next stimulus. Each ignored access is checked at that same point by confirming that the head word and dmaErr are unchanged.

// File: rtl/epDmaPkg.sv
package epDmaPkg;

  typedef enum logic [1:0] {
    SRC_SIE  = 2'd0,
    SRC_DMA  = 2'd1,
    SRC_BYTE = 2'd2
  } srcSel_e;

  typedef struct packed {
    logic    push;
    logic    pop;
    srcSel_e src;
    logic    latchSize;
  } bufCtl_t;

endpackage

// File: rtl/epDmaCtl.sv
module epDmaCtl
  import epDmaPkg::*;
#(
  parameter int EP_NUM = 1,
  parameter int PKT_W  = 7,
  parameter int TOT_W  = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             autoMode,
  input  logic             dmaEn,
  input  logic             dirIn,
  input  logic [PKT_W-1:0] pktSize,
  input  logic [TOT_W-1:0] totalUnits,
  input  logic             loadTotal,
  input  logic             pktDone,
  input  logic             sieWr,
  input  logic             sieRd,
  input  logic             dmaRd,
  input  logic             dmaWr,
  input  logic             cpuByteWr,
  input  logic             cpuByteRd,
  input  logic             cpuClr,
  input  logic             cpuIntClr,
  output bufCtl_t          ctl,
  output logic             dmaReq,
  output logic             irq,
  output logic             dmaErr
);

  localparam bit DMA_OK = (EP_NUM >= 1) && (EP_NUM <= 5);

  logic             reqFlag, intFlag, errFlag;
  logic [PKT_W-1:0] pktCnt;
  logic [TOT_W-1:0] remain;

  logic             dirStrobe, dmaTry, accept, badAcc, autoEff;
  logic [PKT_W:0]   sizeRound;
  logic [PKT_W-1:0] pktUnits, cntInc;
  logic             pktEnd, lastUnit, remainZero;

  // Packet length in 16-bit units, rounded up for an odd byte size.
  assign sizeRound  = {1'b0, pktSize} + 1'b1;
  assign pktUnits   = sizeRound[PKT_W:1];
  assign cntInc     = pktCnt + 1'b1;
  assign pktEnd     = (cntInc == pktUnits);
  assign remainZero = (remain == '0);
  assign lastUnit   = (remain == TOT_W'(1));

  assign dirStrobe = dirIn ? dmaWr : dmaRd;
  assign dmaTry    = DMA_OK && dmaEn && dirStrobe;
  assign accept    = dmaTry && reqFlag;
  assign badAcc    = dmaTry && !reqFlag;
  assign autoEff   = DMA_OK && autoMode;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqFlag <= 1'b0;
      intFlag <= 1'b0;
      errFlag <= 1'b0;
      pktCnt  <= '0;
      remain  <= '0;
    end else begin
      if (loadTotal) begin
        remain <= totalUnits;
      end else if (accept && autoEff && !remainZero) begin
        remain <= remain - 1'b1;
      end

      if (pktDone && (!autoEff || !remainZero)) begin
        reqFlag <= 1'b1;
        pktCnt  <= '0;
      end else if (cpuClr) begin
        reqFlag <= 1'b0;
      end else if (accept && autoEff) begin
        if (lastUnit || pktEnd) begin
          reqFlag <= 1'b0;
          pktCnt  <= '0;
        end else begin
          pktCnt <= cntInc;
        end
      end

      if ((pktDone && !autoEff) || (accept && autoEff && lastUnit)) begin
        intFlag <= 1'b1;
      end else if (cpuIntClr) begin
        intFlag <= 1'b0;
      end

      if (badAcc) begin
        errFlag <= 1'b1;
      end else if (cpuIntClr) begin
        errFlag <= 1'b0;
      end
    end
  end

  // Buffer strobes: the writer and reader swap with the direction.
  always_comb begin
    ctl           = '0;
    ctl.latchSize = pktDone && !dirIn;
    if (dirIn) begin
      ctl.push = (dmaWr && accept) || cpuByteWr;
      ctl.pop  = sieRd;
      ctl.src  = cpuByteWr ? SRC_BYTE : SRC_DMA;
    end else begin
      ctl.push = sieWr;
      ctl.pop  = accept || cpuByteRd;
      ctl.src  = SRC_SIE;
    end
  end

  generate
    if (DMA_OK) begin : g_dmaPath
      assign dmaReq = reqFlag;
    end else begin : g_noDma
      assign dmaReq = 1'b0;
    end
  endgenerate

  assign irq    = intFlag;
  assign dmaErr = errFlag;

endmodule

// File: rtl/epDmaData.sv
module epDmaData
  import epDmaPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PKT_W  = 7,
  parameter int DEPTH  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  bufCtl_t           ctl,
  input  logic [DATA_W-1:0] sieWdata,
  input  logic [DATA_W-1:0] dmaWdata,
  input  logic [7:0]        cpuByte,
  input  logic [PKT_W-1:0]  rxSize,
  output logic [PKT_W-1:0]  rxSizeOut,
  output logic [DATA_W-1:0] portRdata
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  fill;
  logic [DATA_W-1:0] byteWord, pushWord;
  logic              doPush, doPop, isFull, isEmpty;

  generate
    if (DATA_W > 8) begin : g_pad
      assign byteWord = {{(DATA_W-8){1'b0}}, cpuByte};
    end else begin : g_narrow
      assign byteWord = cpuByte[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    unique case (ctl.src)
      SRC_DMA:  pushWord = dmaWdata;
      SRC_BYTE: pushWord = byteWord;
      default:  pushWord = sieWdata;
    endcase
  end

  assign isFull  = (fill == CNT_W'(DEPTH));
  assign isEmpty = (fill == '0);
  assign doPush  = ctl.push && !isFull;
  assign doPop   = ctl.pop && !isEmpty;

  always_ff @(posedge clk) begin
    if (doPush) begin
      mem[wrPtr] <= pushWord;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fill      <= '0;
      rxSizeOut <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PTR_W'(DEPTH-1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == PTR_W'(DEPTH-1)) ? '0 : rdPtr + 1'b1;
      if (doPush && !doPop)      fill <= fill + 1'b1;
      else if (doPop && !doPush) fill <= fill - 1'b1;
      if (ctl.latchSize) rxSizeOut <= rxSize;
    end
  end

  assign portRdata = mem[rdPtr];

endmodule

// File: rtl/epDmaReqSeq.sv
module epDmaReqSeq
  import epDmaPkg::*;
#(
  parameter int EP_NUM = 1,
  parameter int DATA_W = 16,
  parameter int PKT_W  = 7,
  parameter int TOT_W  = 12,
  parameter int DEPTH  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              autoMode,
  input  logic              dmaEn,
  input  logic              dirIn,
  input  logic [PKT_W-1:0]  pktSize,
  input  logic [TOT_W-1:0]  totalUnits,
  input  logic              loadTotal,
  input  logic              pktDone,
  input  logic [PKT_W-1:0]  rxSize,
  input  logic              sieWr,
  input  logic [DATA_W-1:0] sieWdata,
  input  logic              sieRd,
  input  logic              dmaRd,
  input  logic              dmaWr,
  input  logic [DATA_W-1:0] dmaWdata,
  input  logic              cpuByteWr,
  input  logic [7:0]        cpuByte,
  input  logic              cpuByteRd,
  input  logic              cpuClr,
  input  logic              cpuIntClr,
  output logic              dmaReq,
  output logic              irq,
  output logic              dmaErr,
  output logic [PKT_W-1:0]  rxSizeOut,
  output logic [DATA_W-1:0] portRdata
);

  bufCtl_t ctl;

  epDmaCtl #(.EP_NUM(EP_NUM), .PKT_W(PKT_W), .TOT_W(TOT_W)) uCtl (
    .clk(clk), .rstN(rstN), .autoMode(autoMode), .dmaEn(dmaEn), .dirIn(dirIn),
    .pktSize(pktSize), .totalUnits(totalUnits), .loadTotal(loadTotal),
    .pktDone(pktDone), .sieWr(sieWr), .sieRd(sieRd), .dmaRd(dmaRd),
    .dmaWr(dmaWr), .cpuByteWr(cpuByteWr), .cpuByteRd(cpuByteRd),
    .cpuClr(cpuClr), .cpuIntClr(cpuIntClr), .ctl(ctl), .dmaReq(dmaReq),
    .irq(irq), .dmaErr(dmaErr)
  );

  epDmaData #(.DATA_W(DATA_W), .PKT_W(PKT_W), .DEPTH(DEPTH)) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sieWdata(sieWdata),
    .dmaWdata(dmaWdata), .cpuByte(cpuByte), .rxSize(rxSize),
    .rxSizeOut(rxSizeOut), .portRdata(portRdata)
  );

endmodule

// File: rtl/epDmaReqSeqChk.sv
module epDmaReqSeqChk #(
  parameter int EP_NUM = 1
) (
  input logic clk,
  input logic rstN,
  input logic autoMode,
  input logic dmaEn,
  input logic dirIn,
  input logic pktDone,
  input logic dmaRd,
  input logic dmaWr,
  input logic cpuClr,
  input logic dmaReq,
  input logic irq,
  input logic dmaErr
);

  localparam bit DMA_OK = (EP_NUM >= 1) && (EP_NUM <= 5);

  logic actStrobe;
  assign actStrobe = dirIn ? dmaWr : dmaRd;

  a_r2_pkt_sets_req: assert property (@(posedge clk) disable iff (!rstN)
    pktDone && !autoMode && DMA_OK |=> dmaReq);

  a_r3_req_holds: assert property (@(posedge clk) disable iff (!rstN)
    !autoMode && dmaReq && !cpuClr |=> dmaReq);

  a_r4_req_holds_idle: assert property (@(posedge clk) disable iff (!rstN)
    autoMode && dmaReq && !cpuClr && !(dmaEn && actStrobe) |=> dmaReq);

  a_r5_irq_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(pktDone && (!autoMode || !DMA_OK)) ||
                   $past(autoMode && dmaReq && dmaEn && actStrobe));

  a_r7_bad_access_flags: assert property (@(posedge clk) disable iff (!rstN)
    DMA_OK && dmaEn && !dmaReq && actStrobe |=> dmaErr);

  a_r8_err_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dmaErr) |-> $past(dmaEn && !dmaReq && actStrobe));

  a_r11_ctrl_ep_no_req: assert property (@(posedge clk) disable iff (!rstN)
    !DMA_OK |-> !dmaReq);

endmodule

bind epDmaReqSeq epDmaReqSeqChk #(.EP_NUM(EP_NUM)) uChk (
  .clk(clk), .rstN(rstN), .autoMode(autoMode), .dmaEn(dmaEn), .dirIn(dirIn),
  .pktDone(pktDone), .dmaRd(dmaRd), .dmaWr(dmaWr), .cpuClr(cpuClr),
  .dmaReq(dmaReq), .irq(irq), .dmaErr(dmaErr)
);

// File: tb/epDmaReqSeq_test.sv
module epDmaReqSeq_test;

  localparam int CLK_NS = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic autoMode = 0, dmaEn = 0, dirIn = 0, loadTotal = 0, pktDone = 0;
  logic [6:0]  pktSize = 7'd4, rxSize = '0;
  logic [11:0] totalUnits = '0;
  logic sieWr = 0, sieRd = 0, dmaRd = 0, dmaWr = 0;
  logic cpuByteWr = 0, cpuByteRd = 0, cpuClr = 0, cpuIntClr = 0;
  logic [15:0] sieWdata = '0, dmaWdata = '0;
  logic [7:0]  cpuByte = '0;

  logic        dmaReq, irq, dmaErr, dmaReq0, irq0, dmaErr0;
  logic [6:0]  rxSizeOut, rxSizeOut0;
  logic [15:0] portRdata, portRdata0;

  int nChk = 0, nBad = 0;

  always #(CLK_NS/2) clk = ~clk;

  epDmaReqSeq #(.EP_NUM(1)) uut (
    .clk(clk), .rstN(rstN), .autoMode(autoMode), .dmaEn(dmaEn), .dirIn(dirIn),
    .pktSize(pktSize), .totalUnits(totalUnits), .loadTotal(loadTotal),
    .pktDone(pktDone), .rxSize(rxSize), .sieWr(sieWr), .sieWdata(sieWdata),
    .sieRd(sieRd), .dmaRd(dmaRd), .dmaWr(dmaWr), .dmaWdata(dmaWdata),
    .cpuByteWr(cpuByteWr), .cpuByte(cpuByte), .cpuByteRd(cpuByteRd),
    .cpuClr(cpuClr), .cpuIntClr(cpuIntClr), .dmaReq(dmaReq), .irq(irq),
    .dmaErr(dmaErr), .rxSizeOut(rxSizeOut), .portRdata(portRdata)
  );

  // Control-endpoint copy sharing the same stimulus.
  epDmaReqSeq #(.EP_NUM(0)) uut0 (
    .clk(clk), .rstN(rstN), .autoMode(autoMode), .dmaEn(dmaEn), .dirIn(dirIn),
    .pktSize(pktSize), .totalUnits(totalUnits), .loadTotal(loadTotal),
    .pktDone(pktDone), .rxSize(rxSize), .sieWr(sieWr), .sieWdata(sieWdata),
    .sieRd(sieRd), .dmaRd(dmaRd), .dmaWr(dmaWr), .dmaWdata(dmaWdata),
    .cpuByteWr(cpuByteWr), .cpuByte(cpuByte), .cpuByteRd(cpuByteRd),
    .cpuClr(cpuClr), .cpuIntClr(cpuIntClr), .dmaReq(dmaReq0), .irq(irq0),
    .dmaErr(dmaErr0), .rxSizeOut(rxSizeOut0), .portRdata(portRdata0)
  );

  // Auto mode, OUT, 4-byte packets (2 units), 5 units in total.
  // Bits: pktDone dmaRd dmaWr cpuClr cpuIntClr | expReq expIrq expErr
  localparam logic [7:0] VEC [13] = '{
    8'b00000_000,  // idle
    8'b10000_100,  // R2 packet arrives
    8'b01000_100,  // R4 unit 1 of 2
    8'b01000_000,  // R4 unit 2 of 2 drops request
    8'b01000_001,  // R7 access with no request
    8'b00001_000,  // R7 clear error
    8'b10000_100,  // R2 next packet
    8'b01000_100,  // R5 remain 2
    8'b01000_000,  // R4 packet done, remain 1
    8'b10000_100,  // R2 short last packet
    8'b01000_010,  // R5 total exhausted, irq
    8'b10000_010,  // R6 no request after exhaustion
    8'b00001_000   // R5 irq cleared
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    pktDone = 0; sieWr = 0; sieRd = 0; dmaRd = 0; dmaWr = 0;
    cpuByteWr = 0; cpuByteRd = 0; cpuClr = 0; cpuIntClr = 0; loadTotal = 0;
  endtask

  task automatic pushSie(input logic [15:0] w);
    sieWr = 1; sieWdata = w; tick();
  endtask

  initial begin
    #(CLK_NS * 200000);
    nChk++; nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    tick(); tick();
    rstN = 1;
    tick();
    chk("R1 dmaReq", dmaReq, 0);
    chk("R1 irq", irq, 0);
    chk("R1 dmaErr", dmaErr, 0);
    chk("R1 rxSizeOut", rxSizeOut, 0);

    // Table walk
    autoMode = 1; dmaEn = 1; dirIn = 0; pktSize = 7'd4;
    totalUnits = 12'd5; loadTotal = 1; tick();
    for (int i = 0; i < 13; i++) begin
      {pktDone, dmaRd, dmaWr, cpuClr, cpuIntClr} = VEC[i][7:3];
      tick();
      chk($sformatf("R4/R5 step %0d dmaReq", i), dmaReq, VEC[i][2]);
      chk($sformatf("R5 step %0d irq", i), irq, VEC[i][1]);
      chk($sformatf("R7 step %0d dmaErr", i), dmaErr, VEC[i][0]);
    end

    // Per-packet OUT with data order and odd last byte
    autoMode = 0;
    pushSie(16'h1111); pushSie(16'h2222); pushSie(16'h0033);
    pktDone = 1; rxSize = 7'd5; tick();
    chk("R2 dmaReq", dmaReq, 1);
    chk("R2 rxSizeOut", rxSizeOut, 5);
    chk("R3 irq per packet", irq, 1);
    chk("R11 ctrl ep no req", dmaReq0, 0);
    chk("R9 head", portRdata, 16'h1111);
    dmaRd = 1; tick();
    chk("R9 second word", portRdata, 16'h2222);
    chk("R3 req held", dmaReq, 1);
    dmaRd = 1; tick();
    chk("R9 third word", portRdata, 16'h0033);
    chk("R3 req held after 2", dmaReq, 1);
    chk("R11 ctrl ep buffer untouched", portRdata0, 16'h1111);
    chk("R11 ctrl ep no err", dmaErr0, 0);
    chk("R10 low byte", portRdata[7:0], 8'h33);
    cpuByteRd = 1; tick();
    cpuClr = 1; tick();
    chk("R3 cleared by cpu", dmaReq, 0);
    cpuIntClr = 1; tick();
    chk("R7 irq cleared", irq, 0);

    // DMA disabled and wrong-direction strobes
    pushSie(16'h4444);
    pktDone = 1; tick();
    dmaEn = 0; dmaRd = 1; tick();
    chk("R8 buffer kept", portRdata, 16'h4444);
    chk("R8 no err", dmaErr, 0);
    dmaEn = 1; dmaWr = 1; dmaWdata = 16'hBEEF; tick();
    chk("R12 buffer kept", portRdata, 16'h4444);
    chk("R12 no err", dmaErr, 0);
    dmaRd = 1; tick();
    cpuClr = 1; tick();

    // Access while no request pending
    pushSie(16'h5555);
    dmaRd = 1; tick();
    chk("R7 err set", dmaErr, 1);
    chk("R7 buffer kept", portRdata, 16'h5555);
    cpuIntClr = 1; tick();
    chk("R7 err cleared", dmaErr, 0);
    cpuByteRd = 1; tick();

    // IN direction: DMA word then CPU odd byte
    dirIn = 1;
    pktDone = 1; tick();
    dmaWr = 1; dmaWdata = 16'h0A0B; tick();
    cpuByteWr = 1; cpuByte = 8'h99; tick();
    chk("R9 IN head", portRdata, 16'h0A0B);
    sieRd = 1; tick();
    chk("R10 byte word", portRdata, 16'h0099);
    chk("R12 IN no err", dmaErr, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule